// File: doc/BRIEF.md
# Signalling Tone Gate and Frequency Monitor

This block drives the on/off control of the 22 kHz signalling tone that rides on a dish-supply output. It also judges whether the tone sensed back from the line has a plausible frequency. The tone is made inside the block by dividing the system clock. Two register bits and one data pin decide whether the gate output carries that internal tone, nothing, or a square wave supplied from outside. With the pass-through bit clear, the internal tone is gated. The tone-enable bit turns it on for good, and the data pin acts as an on/off envelope. With the pass-through bit set, the synchronised pin itself is copied to the output.

A monitor watches the sensed-tone comparator output and measures the time between its rising edges. It sets a fault bit when the frequency leaves a window of roughly 16.5 kHz to 29.5 kHz. It only changes that bit after several periods in a row agree. A missing tone counts as a fault while a tone is expected, and that fault is reported without waiting for agreement. Only the digital gate and the fault bit are produced. Amplitude sensing and the analog injection are done elsewhere.

Top module: `tone_gate_monitor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `tone_gate_o` and `tone_fault_o` are both 0.
- R2: With `extm_i`=0 and `ten_i`=1, `tone_gate_o` is a continuous square wave. Every high phase and every low phase lasts exactly HALF_DIV = CLK_HZ/(2*TONE_HZ) clocks, which is 50 clocks when CLK_HZ = 2.2 MHz.
- R3: With `extm_i`=0, the envelope is on while `ten_i` or `env_pin_i` is 1, and the output then carries the internal tone. Once both have been 0 for more than one half period, `tone_gate_o` stays at 0.
- R4: With `extm_i`=0, the envelope is only switched on or off where a tone half period ends. Every high and low pulse on `tone_gate_o` is therefore exactly HALF_DIV clocks long, including the first and the last pulse of a burst.
- R5: With `extm_i`=1, `tone_gate_o` equals `env_pin_i` delayed by SYNC_STAGES+1 clocks, which is 3 clocks by default. `ten_i` has no effect in this mode.
- R6: A measured period P, in clocks between detected rising edges of `tone_det_i`, is in range when ceil(CLK_HZ/HIGH_HZ) <= P <= floor(CLK_HZ/LOW_HZ). At 2.2 MHz that is 75..133 clocks. Once settled, `tone_fault_o` is 0 for in-range periods and 1 for periods of 74 or fewer and of 134 or more.
- R7: `tone_fault_o` changes from a measurement only after AGREE_N consecutive periods (default 4) fall in the same class. A run of AGREE_N-1 deviating periods leaves it unchanged.
- R8: While a tone is expected, a gap of TIMEOUT clocks without a rising edge on `tone_det_i` sets `tone_fault_o` to 1 at once. TIMEOUT is TIMEOUT_US microseconds of clock, which is 220 clocks at 2.2 MHz.
- R9: A tone is expected when `extm_i`=1 or the envelope is on. While none is expected, no timeout occurs and `tone_fault_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| ten_i | input | 1 | Tone-enable control bit: continuous internal tone |
| extm_i | input | 1 | Mode bit: 1 passes the pin waveform through, 0 uses it as envelope |
| env_pin_i | input | 1 | Asynchronous tone data pin (envelope or external square wave) |
| tone_det_i | input | 1 | Asynchronous comparator output of the tone sensed on the line |
| tone_gate_o | output | 1 | Gate driving the tone injector |
| tone_fault_o | output | 1 | 1 when the sensed tone frequency is out of window or missing |

## Verification
A divider count that slips shows up on the very next gate pulse, as a width other than HALF_DIV. A stale envelope state shows up within one half period, either as a truncated pulse or as a tone that keeps running after the envelope is dropped. A wrong run counter in the monitor moves the fault bit one period too early or too late. This is exposed by a burst of exactly AGREE_N-1 deviating periods and by the boundary periods 74/75 and 133/134. A wrong timeout counter shifts the fault by tens of clocks after the last edge, so the fault is sampled both clearly before and clearly after the nominal gap.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        MODE_QUIET    = 2'd0,
        MODE_ENVELOPE = 2'd1,
        MODE_PASS     = 2'd2
    } gate_mode_e;

    typedef enum logic {
        CLS_INSIDE  = 1'b0,
        CLS_OUTSIDE = 1'b1
    } per_class_e;

    typedef struct packed {
        logic       valid;
        per_class_e cls;
    } period_meas_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic per_class_e classify(input int per, input int lo, input int hi);
        return ((per >= lo) && (per <= hi)) ? CLS_INSIDE : CLS_OUTSIDE;
    endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st_q[0] <= '0;
                else     st_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st_q[s] <= '0;
                else     st_q[s] <= st_q[s-1];
            end
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic phase_o,
    output logic half_tick_o
);
    localparam int DW = $clog2(HALF_DIV + 1);

    logic [DW-1:0] cnt_q;
    logic          phase_q;

    assign half_tick_o = (cnt_q == DW'(HALF_DIV - 1));
    assign phase_o     = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (half_tick_o) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + DW'(1);
        end
    end

    // R2: phase flips exactly on a half-period strobe and holds otherwise
    p_phase_flip_r2: assert property (@(posedge clk) disable iff (rst)
        $past(half_tick_o) |-> (phase_q != $past(phase_q)));
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(half_tick_o) |-> $stable(phase_q));
endmodule

// File: rtl/tone_gate.sv
module tone_gate
    import tone_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ten_i,
    input  logic extm_i,
    input  logic pin_s_i,
    input  logic phase_i,
    input  logic half_tick_i,
    output logic gate_o,
    output logic expect_o
);
    gate_mode_e mode_w;
    logic       env_on_q;
    logic       out_q;

    always_comb begin
        if (extm_i)              mode_w = MODE_PASS;
        else if (ten_i | pin_s_i) mode_w = MODE_ENVELOPE;
        else                     mode_w = MODE_QUIET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            env_on_q <= 1'b0;
            out_q    <= 1'b0;
        end else if (mode_w == MODE_PASS) begin
            env_on_q <= 1'b0;
            out_q    <= pin_s_i;
        end else if (half_tick_i) begin
            env_on_q <= (mode_w == MODE_ENVELOPE);
            out_q    <= (mode_w == MODE_ENVELOPE) & ~phase_i;
        end else begin
            out_q    <= out_q & env_on_q;
        end
    end

    assign gate_o   = out_q;
    assign expect_o = extm_i | env_on_q;

    // R4: in envelope operation the gate only moves on a half-period boundary
    p_boundary_only_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(extm_i) && !$past(extm_i, 2) && (out_q != $past(out_q)))
            |-> $past(half_tick_i));
    // R3: a closed envelope keeps the gate low
    p_quiet_low_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(extm_i) && !env_on_q) |-> !out_q);
    // R5: pass-through copies the synchronised pin one clock later
    p_pass_follow_r5: assert property (@(posedge clk) disable iff (rst)
        $past(extm_i) |-> (out_q == $past(pin_s_i)));
endmodule

// File: rtl/tone_freq_mon.sv
module tone_freq_mon
    import tone_pkg::*;
#(
    parameter int PER_MIN = 75,
    parameter int PER_MAX = 133,
    parameter int TIMEOUT = 220,
    parameter int AGREE_N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic det_i,
    input  logic expect_i,
    output logic fault_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam int RW = $clog2(AGREE_N + 1);

    logic          det_d_q;
    logic [CW-1:0] cnt_q;
    logic          armed_q;
    per_class_e    last_q;
    logic [RW-1:0] run_q;
    logic          flag_q;

    logic          edge_evt;
    logic          tmo_evt;
    period_meas_t  meas_w;
    logic [RW-1:0] run_nx;

    assign edge_evt = det_i & ~det_d_q;
    assign tmo_evt  = expect_i & ~edge_evt & (cnt_q == CW'(TIMEOUT - 1));

    always_comb begin
        meas_w.valid = edge_evt & armed_q;
        meas_w.cls   = classify(int'(cnt_q), PER_MIN, PER_MAX);
        if ((run_q != '0) && (meas_w.cls == last_q))
            run_nx = (run_q == RW'(AGREE_N)) ? run_q : run_q + RW'(1);
        else
            run_nx = RW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_d_q <= 1'b0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            last_q  <= CLS_INSIDE;
            run_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            det_d_q <= det_i;
            if (!expect_i) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
                run_q   <= '0;
            end else if (edge_evt) begin
                cnt_q   <= CW'(1);
                armed_q <= 1'b1;
                if (meas_w.valid) begin
                    last_q <= meas_w.cls;
                    run_q  <= run_nx;
                    if (run_nx == RW'(AGREE_N))
                        flag_q <= (meas_w.cls == CLS_OUTSIDE);
                end
            end else if (tmo_evt) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
                run_q   <= '0;
                flag_q  <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + CW'(1);
            end
        end
    end

    assign fault_o = flag_q;

    // R8: the gap counter never passes the timeout limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(TIMEOUT));
    // R8: a timeout raises the fault on the next cycle
    p_timeout_sets_r8: assert property (@(posedge clk) disable iff (rst)
        $past(tmo_evt) |-> flag_q);
    // R7: the agreement run never exceeds its target
    p_run_bound_r7: assert property (@(posedge clk) disable iff (rst)
        run_q <= RW'(AGREE_N));
    // R7: the fault bit only moves on a measurement edge or a timeout
    p_flag_event_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(flag_q) |-> $past(edge_evt || tmo_evt));
    // R9: without an expected tone the gap counter stays cleared
    p_idle_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(expect_i) |-> (cnt_q == '0));
endmodule

// File: rtl/tone_gate_monitor.sv
module tone_gate_monitor
    import tone_pkg::*;
#(
    parameter int CLK_HZ      = 250_000_000,
    parameter int TONE_HZ     = 22_000,
    parameter int LOW_HZ      = 16_500,
    parameter int HIGH_HZ     = 29_500,
    parameter int TIMEOUT_US  = 100,
    parameter int AGREE_N     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ten_i,
    input  logic extm_i,
    input  logic env_pin_i,
    input  logic tone_det_i,
    output logic tone_gate_o,
    output logic tone_fault_o
);
    localparam int HALF_DIV = CLK_HZ / (2 * TONE_HZ);
    localparam int PER_MIN  = ceil_div(CLK_HZ, HIGH_HZ);
    localparam int PER_MAX  = CLK_HZ / LOW_HZ;
    localparam int TIMEOUT  = (CLK_HZ / 1000) * TIMEOUT_US / 1000;

    logic [1:0] raw_w;
    logic [1:0] sync_w;
    logic       phase_w;
    logic       half_tick_w;
    logic       expect_w;

    assign raw_w = {tone_det_i, env_pin_i};

    tone_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_w),
        .q_o (sync_w)
    );

    tone_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk         (clk),
        .rst         (rst),
        .phase_o     (phase_w),
        .half_tick_o (half_tick_w)
    );

    tone_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .ten_i       (ten_i),
        .extm_i      (extm_i),
        .pin_s_i     (sync_w[0]),
        .phase_i     (phase_w),
        .half_tick_i (half_tick_w),
        .gate_o      (tone_gate_o),
        .expect_o    (expect_w)
    );

    tone_freq_mon #(
        .PER_MIN (PER_MIN),
        .PER_MAX (PER_MAX),
        .TIMEOUT (TIMEOUT),
        .AGREE_N (AGREE_N)
    ) u_mon (
        .clk      (clk),
        .rst      (rst),
        .det_i    (sync_w[1]),
        .expect_i (expect_w),
        .fault_o  (tone_fault_o)
    );

    // R1: both outputs start low in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!tone_gate_o && !tone_fault_o));
endmodule

// File: tb/tone_gate_monitor_tb_top.sv
`timescale 1ns/1ps
module tone_gate_monitor_tb_top;
    localparam int HALF = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ten = 1'b0;
    logic extm = 1'b0;
    logic pin = 1'b0;
    logic det = 1'b0;
    logic gate;
    logic fault;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    tone_gate_monitor #(.CLK_HZ(2_200_000)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .ten_i        (ten),
        .extm_i       (extm),
        .env_pin_i    (pin),
        .tone_det_i   (det),
        .tone_gate_o  (gate),
        .tone_fault_o (fault)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int window, input int drop_at,
                           output int trans, output int bad, output int badw);
        logic prev;
        int   last;
        prev  = gate;
        last  = -1;
        trans = 0;
        bad   = 0;
        badw  = HALF;
        for (int i = 0; i < window; i++) begin
            if (i == drop_at) pin = 1'b0;
            @(negedge clk);
            if (gate !== prev) begin
                if (last >= 0 && (i - last) != HALF) begin
                    bad++;
                    badw = i - last;
                end
                last = i;
                trans++;
                prev = gate;
            end
        end
    endtask

    task automatic send(input int n, input int per, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            det = 1'b1;
            for (int c = 0; c < per / 2; c++) begin
                @(negedge clk);
                if (fault) hits++;
            end
            det = 1'b0;
            for (int c = 0; c < per - per / 2; c++) begin
                @(negedge clk);
                if (fault) hits++;
            end
        end
    endtask

    task automatic t_reset();
        step(5);
        check(gate == 1'b0 && fault == 1'b0, "R1", "outputs in reset", {gate, fault}, 0);
        rst = 1'b0;
        step(1);
        check(gate == 1'b0 && fault == 1'b0, "R1", "outputs after release", {gate, fault}, 0);
    endtask

    task automatic t_continuous();
        int tr, bad, bw;
        extm = 1'b0; pin = 1'b0; ten = 1'b1;
        step(120);
        measure(600, -1, tr, bad, bw);
        check(tr >= 10, "R2", "transitions of continuous tone", tr, 10);
        check(bad == 0, "R2", "half-period width", bw, HALF);
    endtask

    task automatic t_quiet();
        int highs = 0;
        ten = 1'b0; pin = 1'b0;
        step(60);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (gate) highs++;
        end
        check(highs == 0, "R3", "gate high cycles with envelope closed", highs, 0);
    endtask

    task automatic t_envelope();
        int tr, bad, bw;
        ten = 1'b0;
        step(17);
        pin = 1'b1;
        measure(700, 413, tr, bad, bw);
        check(tr >= 6, "R3", "tone present under pin envelope", tr, 6);
        check(bad == 0, "R4", "pulse width across burst start/stop", bw, HALF);
        check(gate == 1'b0, "R3", "gate after envelope dropped", gate, 0);
    endtask

    task automatic t_pass();
        logic [4:0] pat = 5'b01101;
        logic prev_v = 1'b0;
        int lows = 0;
        extm = 1'b1; ten = 1'b1; pin = 1'b0;
        step(6);
        for (int k = 0; k < 5; k++) begin
            pin = pat[k];
            step(2);
            check(gate == prev_v, "R5", "gate before latency elapsed", gate, prev_v);
            step(1);
            check(gate == pat[k], "R5", "gate after 3-clock latency", gate, pat[k]);
            prev_v = pat[k];
            step(4);
        end
        pin = 1'b0;
        step(4);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (gate) lows++;
        end
        check(lows == 0, "R5", "ten ignored in pass-through", lows, 0);
        extm = 1'b0; ten = 1'b1;
        step(60);
    endtask

    task automatic t_window();
        int h;
        send(6, 100, h); check(fault == 1'b0, "R6", "period 100", fault, 0);
        send(6, 60, h);  check(fault == 1'b1, "R6", "period 60", fault, 1);
        send(6, 100, h); check(fault == 1'b0, "R6", "period 100 again", fault, 0);
        send(6, 74, h);  check(fault == 1'b1, "R6", "period 74 (above high limit)", fault, 1);
        send(6, 75, h);  check(fault == 1'b0, "R6", "period 75 (edge of window)", fault, 0);
        send(6, 134, h); check(fault == 1'b1, "R6", "period 134 (below low limit)", fault, 1);
        send(6, 133, h); check(fault == 1'b0, "R6", "period 133 (edge of window)", fault, 0);
    endtask

    task automatic t_agree();
        int h1, h2;
        send(6, 100, h1);
        check(fault == 1'b0, "R7", "settled in range", fault, 0);
        send(3, 60, h1);
        send(6, 100, h2);
        check(h1 + h2 == 0, "R7", "fault cycles after 3 deviating periods", h1 + h2, 0);
        send(4, 60, h1);
        send(1, 100, h2);
        check(fault == 1'b1, "R7", "fault after 4 deviating periods", fault, 1);
    endtask

    task automatic t_timeout();
        int h;
        send(6, 100, h);
        check(fault == 1'b0, "R8", "in range before gap", fault, 0);
        step(90);
        check(fault == 1'b0, "R8", "no fault early in gap", fault, 0);
        step(60);
        check(fault == 1'b1, "R8", "fault after timeout gap", fault, 1);
    endtask

    task automatic t_idle();
        int h;
        send(6, 100, h);
        check(fault == 1'b0, "R9", "in range before idle", fault, 0);
        ten = 1'b0;
        step(500);
        check(fault == 1'b0, "R9", "no timeout without expected tone", fault, 0);
        ten = 1'b1;
        step(300);
        check(fault == 1'b1, "R8", "timeout once tone expected again", fault, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_continuous();
        t_quiet();
        t_envelope();
        t_pass();
        t_window();
        t_agree();
        t_timeout();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule